// File: doc/BRIEF.md
# Dual-Identity I2C Register File Target

This block is an I2C target that fronts a 48-entry byte store. SCL and SDA are sampled with the system clock through a short synchronizer. START, repeated START and STOP are recovered from the sampled lines. The block answers to two separate 7-bit device identities. It pulls SDA low through an open-drain enable for ACK and for read data, and releases SDA at all other times.

Bus masters can do three things:
- Write a single byte: identity with R/W=0, an address byte, then one data byte.
- Read from the current pointer: identity with R/W=1, then data bytes.
- Do a random read: a dummy write of the address, a repeated START, then identity with R/W=1. The identity in the read phase must be the same one used in the dummy write.

A word pointer selects the byte to send. It advances after every byte sent and wraps from the last entry back to entry 0.

The rest of the chip reaches the same storage through a local port, which has one write path and one combinational read path. A power-fail input cuts the serial side off completely. While it is asserted, the storage and the local port keep working.

Top module: `i2c_dual_id_regfile`

## Requirements
- R1: A byte whose upper seven bits (received MSB first) equal 1101111 or 1010111 gets an ACK: SDA is pulled low in the ninth clock. Any other identity gets no ACK, and every later byte is ignored until the next START.
- R2: The write sequence is START, identity with R/W=0 (bit 0), address byte, data byte, STOP. All three bytes are ACKed, and the data lands at the addressed entry, where the local port can read it.
- R3: In one write transaction, any data byte after the first is not ACKed and does not change the storage.
- R4: In a random read, a repeated START after the address byte followed by the same identity with R/W=1 is ACKed. The entries are then sent MSB first, starting at that address. If the read-phase identity differs from the dummy-write identity, it gets no ACK and SDA is never pulled low.
- R5: The word pointer is 0 after reset. A read with no preceding address starts at the pointer. A write leaves the pointer at the written address.
- R6: The pointer advances by one for each byte sent, and goes from 47 to 0. Bytes keep coming while the master ACKs. After a master NACK, SDA stays released.
- R7: An address byte of 48 or more selects entry (value mod 48).
- R8: While `pwr_fail` is high, SDA is released, no bus byte is ACKed and the bus changes no entry. The stored contents and the local port are unaffected.
- R9: A local write to an address below 48 updates that entry at the clock edge, and `loc_rdata` shows the entry combinationally. For addresses 48 to 63, writes are ignored and reads return 0. All entries are 0 after reset.
- R10: If a local write and a bus data-byte write hit the same entry in the same cycle, the local value is kept.
- R11: SDA starts being pulled low only while SCL is low. A START in the middle of a byte abandons that byte, and the next byte is counted from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | High cuts off the serial interface |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| loc_we | input | 1 | Local write strobe |
| loc_addr | input | 6 | Local entry address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data (combinational) |

## Verification
The local write port and the commit of a bus data byte can land on the same entry in the same clock cycle. The bench provokes this by raising `loc_we` for that entry at the same moment SCL rises for the last bit of the data byte. It holds `loc_we` across the few cycles in which the synchronized rising edge commits the bus byte. The result is judged in two ways: the bus byte must still be ACKed, and the entry read back afterwards must hold the local value, not the bus value.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ID,
    PH_ADDR,
    PH_DATA,
    PH_READ,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store #(
  parameter int DEPTH = 48,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic          loc_ok;

  assign loc_ok = (loc_addr < AW'(DEPTH));

  // local port is applied last, so it wins a same-entry collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (bus_we) mem[bus_addr] <= bus_wdata;
      if (loc_we && loc_ok) mem[loc_addr] <= loc_wdata;
    end
  end

  assign loc_rdata = loc_ok ? mem[loc_addr] : '0;
  assign bus_rdata = mem[bus_addr];
endmodule

// File: rtl/i2c_rf_ctrl.sv
module i2c_rf_ctrl
  import i2c_rf_pkg::*;
#(
  parameter int         DEPTH = 48,
  parameter int         AW    = 6,
  parameter logic [6:0] ID_A  = 7'h6F,
  parameter logic [6:0] ID_B  = 7'h57
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [DW-1:0] rd_byte,
  output logic          sda_oe,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  output logic [AW-1:0] ptr
);
  phase_e        phase_q, phase_d, nxt_q, nxt_d;
  logic [3:0]    bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d, rx;
  logic          ack_q, ack_d, oe_q, oe_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          id_q, id_d, dummy_q, dummy_d, wdone_q, wdone_d;
  logic          hit, sel, receiving, load_now;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] addr_fold(input logic [7:0] a);
    logic [7:0] m;
    m = a % 8'(DEPTH);
    return m[AW-1:0];
  endfunction

  assign rx        = {sh_q[DW-2:0], sda_s};
  assign sel       = (rx[7:1] == ID_B);
  assign hit       = (rx[7:1] == ID_A) | sel;
  assign receiving = (phase_q == PH_ID) | (phase_q == PH_ADDR) | (phase_q == PH_DATA);

  always_comb begin
    phase_d  = phase_q;
    nxt_d    = nxt_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    ack_d    = ack_q;
    oe_d     = oe_q;
    ptr_d    = ptr_q;
    id_d     = id_q;
    dummy_d  = dummy_q;
    wdone_d  = wdone_q;
    bus_we   = 1'b0;
    load_now = 1'b0;
    if (pwr_fail || stop_ev) begin
      phase_d = PH_IDLE;
      bit_d   = '0;
      oe_d    = 1'b0;
      dummy_d = 1'b0;
    end else if (start_ev) begin
      phase_d = PH_ID;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (scl_rise) begin
      if (receiving && bit_q < 4'd8) begin
        sh_d  = rx;
        bit_d = bit_q + 4'd1;
        if (bit_q == 4'd7) begin
          case (phase_q)
            PH_ID: begin
              if (!rx[0]) begin
                ack_d   = hit;
                nxt_d   = PH_ADDR;
                dummy_d = 1'b0;
                if (hit) id_d = sel;
              end else begin
                ack_d = hit && (!dummy_q || (sel == id_q));
                nxt_d = PH_READ;
              end
            end
            PH_ADDR: begin
              ack_d   = 1'b1;
              ptr_d   = addr_fold(rx);
              dummy_d = 1'b1;
              wdone_d = 1'b0;
              nxt_d   = PH_DATA;
            end
            default: begin
              ack_d = !wdone_q;
              nxt_d = PH_DATA;
              if (!wdone_q) begin
                bus_we  = 1'b1;
                wdone_d = 1'b1;
                dummy_d = 1'b0;
              end
            end
          endcase
        end
      end else if (phase_q == PH_READ) begin
        if (bit_q < 4'd8) begin
          bit_d = bit_q + 4'd1;
        end else if (bit_q == 4'd8) begin
          ack_d = ~sda_s;
          bit_d = 4'd9;
        end
      end
    end else if (scl_fall) begin
      if (receiving) begin
        if (bit_q == 4'd8) begin
          oe_d  = ack_q;
          bit_d = 4'd9;
        end else if (bit_q == 4'd9) begin
          oe_d  = 1'b0;
          bit_d = '0;
          if (!ack_q)                phase_d  = PH_SKIP;
          else if (nxt_q == PH_READ) load_now = 1'b1;
          else                       phase_d  = nxt_q;
        end
      end else if (phase_q == PH_READ) begin
        if (bit_q >= 4'd1 && bit_q <= 4'd7) begin
          sh_d = {sh_q[DW-2:0], 1'b0};
          oe_d = ~sh_q[DW-2];
        end else if (bit_q == 4'd8) begin
          oe_d = 1'b0;
        end else if (bit_q == 4'd9) begin
          if (ack_q) begin
            load_now = 1'b1;
          end else begin
            phase_d = PH_SKIP;
            oe_d    = 1'b0;
            bit_d   = '0;
          end
        end
      end
    end
    if (load_now) begin
      phase_d = PH_READ;
      sh_d    = rd_byte;
      oe_d    = ~rd_byte[DW-1];
      ptr_d   = ptr_inc(ptr_q);
      bit_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      nxt_q   <= PH_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      ptr_q   <= '0;
      id_q    <= 1'b0;
      dummy_q <= 1'b0;
      wdone_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      nxt_q   <= nxt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
      ptr_q   <= ptr_d;
      id_q    <= id_d;
      dummy_q <= dummy_d;
      wdone_q <= wdone_d;
    end
  end

  assign sda_oe    = oe_q;
  assign bus_wdata = rx;
  assign ptr       = ptr_q;
endmodule

// File: rtl/i2c_dual_id_regfile.sv
module i2c_dual_id_regfile
  import i2c_rf_pkg::*;
#(
  parameter int         DEPTH       = 48,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ID_A        = 7'h6F,
  parameter logic [6:0] ID_B        = 7'h57,
  localparam int        AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic          bus_we;
  logic [DW-1:0] bus_wdata, rd_byte;
  logic [AW-1:0] ptr;

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_rf_ctrl #(.DEPTH(DEPTH), .AW(AW), .ID_A(ID_A), .ID_B(ID_B)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .bus_we(bus_we), .bus_wdata(bus_wdata), .ptr(ptr)
  );

  i2c_rf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .bus_we(bus_we), .bus_addr(ptr), .bus_wdata(bus_wdata), .bus_rdata(rd_byte)
  );
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk #(
  parameter int DEPTH = 48,
  parameter int AW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          bus_we,
  input logic [AW-1:0] ptr,
  input logic          loc_we,
  input logic [AW-1:0] loc_addr,
  input logic [7:0]    loc_wdata,
  input logic [7:0]    loc_rdata
);
  // R11: pull-down begins only in the low half of SCL
  a_r11_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R8: power fail releases the line on the next cycle
  a_r8_pwrfail_release: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !sda_oe);

  // R8: no bus write while cut off
  a_r8_pwrfail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> !bus_we);

  // R6: pointer never leaves the 48-entry space
  a_r6_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < AW'(DEPTH));

  // R9/R10: a local write is always visible on the next cycle
  a_r9_loc_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_we && loc_addr < AW'(DEPTH)) |=>
      (!$stable(loc_addr) || loc_rdata == $past(loc_wdata)));
endmodule

bind i2c_dual_id_regfile i2c_rf_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .sda_oe(sda_oe), .scl_s(scl_s),
  .bus_we(bus_we), .ptr(ptr), .loc_we(loc_we), .loc_addr(loc_addr),
  .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
);

// File: tb/i2c_dual_id_regfile_bench.sv
`timescale 1ns/1ps
module i2c_dual_id_regfile_bench;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n, pwr_fail, scl_m, sda_m, loc_we;
  logic [5:0] loc_addr;
  logic [7:0] loc_wdata;
  logic       sda_oe;
  logic [7:0] loc_rdata;
  logic       sda_line;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_dual_id_regfile u_i2c_dual_id_regfile (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic loc_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); loc_addr = a; loc_wdata = d; loc_we = 1'b1;
    @(negedge clk); loc_we = 1'b0;
  endtask

  task automatic loc_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); loc_addr = a; #1 d = loc_rdata;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic i2c_bit(input logic v);
    sda_m = v; wq();
    scl_m = 1'b1; wq();
    scl_m = 1'b0;
  endtask

  task automatic i2c_ackbit(output logic ack);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic i2c_tx(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) i2c_bit(b[i]);
    i2c_ackbit(ack);
  endtask

  // last bit's SCL rise coincides with a local write to the same entry
  task automatic i2c_tx_clash(input logic [7:0] b, input logic [5:0] a,
                              input logic [7:0] lv, output logic ack);
    for (int i = 7; i >= 1; i--) i2c_bit(b[i]);
    sda_m = b[0]; wq();
    scl_m = 1'b1; loc_addr = a; loc_wdata = lv; loc_we = 1'b1;
    repeat (4) @(negedge clk);
    loc_we = 1'b0;
    repeat (Q - 4) @(negedge clk);
    scl_m = 1'b0;
    i2c_ackbit(ack);
  endtask

  task automatic i2c_rx(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_m = 1'b1; wq();
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    wq();
    sda_m = ~mack; wq();
    scl_m = 1'b1; wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R9 reset sda_oe", int'(sda_oe), 0);
    loc_rd(6'd5, d);  check("R9 reset entry 5", d, 8'h00);
    loc_rd(6'd47, d); check("R9 reset entry 47", d, 8'h00);
  endtask

  task automatic t_current_first();
    logic ack; logic [7:0] d;
    loc_wr(6'd0, 8'h9C);
    i2c_start(); i2c_tx(8'hDF, ack);
    check("R5 read ID ack", ack, 1);
    i2c_rx(1'b0, d); i2c_stop();
    check("R5 current read from reset pointer", d, 8'h9C);
  endtask

  task automatic t_local();
    logic [7:0] d;
    loc_wr(6'd10, 8'hA5);
    loc_rd(6'd10, d); check("R9 local write/read", d, 8'hA5);
    loc_wr(6'd50, 8'h5A);
    loc_rd(6'd50, d); check("R9 out-of-range read is zero", d, 8'h00);
    loc_rd(6'd2, d);  check("R9 out-of-range write ignored (alias 2)", d, 8'h00);
  endtask

  task automatic t_ident();
    logic ack;
    i2c_start(); i2c_tx(8'hDE, ack); check("R1 identity 1101111 acked", ack, 1); i2c_stop();
    i2c_start(); i2c_tx(8'hAE, ack); check("R1 identity 1010111 acked", ack, 1); i2c_stop();
    i2c_start(); i2c_tx(8'hA0, ack); check("R1 foreign identity nacked", ack, 0);
    i2c_tx(8'h00, ack); check("R1 bytes after foreign identity ignored", ack, 0);
    i2c_stop();
  endtask

  task automatic t_write();
    logic ack; logic [7:0] d;
    i2c_start();
    i2c_tx(8'hDE, ack); check("R2 id ack", ack, 1);
    i2c_tx(8'h05, ack); check("R2 addr ack", ack, 1);
    i2c_tx(8'h3C, ack); check("R2 data ack", ack, 1);
    i2c_stop();
    loc_rd(6'd5, d); check("R2 data stored", d, 8'h3C);
  endtask

  task automatic t_write_extra();
    logic ack; logic [7:0] d;
    loc_wr(6'd7, 8'h77);
    i2c_start();
    i2c_tx(8'hDE, ack); i2c_tx(8'h06, ack);
    i2c_tx(8'h11, ack); check("R3 first data acked", ack, 1);
    i2c_tx(8'h22, ack); check("R3 second data nacked", ack, 0);
    i2c_stop();
    loc_rd(6'd6, d); check("R3 first data kept", d, 8'h11);
    loc_rd(6'd7, d); check("R3 neighbour untouched", d, 8'h77);
  endtask

  task automatic t_addr_mod();
    logic ack; logic [7:0] d;
    i2c_start(); i2c_tx(8'hAE, ack); i2c_tx(8'h35, ack);
    check("R7 addr 35h acked", ack, 1);
    i2c_tx(8'h5A, ack); i2c_stop();
    loc_rd(6'd5, d); check("R7 35h folds to 5", d, 8'h5A);
    i2c_start(); i2c_tx(8'hAE, ack); i2c_tx(8'hFF, ack); i2c_tx(8'hE1, ack); i2c_stop();
    loc_rd(6'd15, d); check("R7 FFh folds to 15", d, 8'hE1);
  endtask

  task automatic t_random_read();
    logic ack; logic [7:0] d;
    loc_wr(6'd46, 8'h46); loc_wr(6'd47, 8'h47);
    loc_wr(6'd0, 8'h80);  loc_wr(6'd1, 8'h81); loc_wr(6'd2, 8'h82);
    i2c_start(); i2c_tx(8'hDE, ack); i2c_tx(8'd46, ack);
    i2c_rstart(); i2c_tx(8'hDF, ack); check("R4 read identity acked", ack, 1);
    i2c_rx(1'b1, d); check("R4 first byte at address", d, 8'h46);
    i2c_rx(1'b1, d); check("R6 pointer advances", d, 8'h47);
    i2c_rx(1'b1, d); check("R6 wraps 47 to 0", d, 8'h80);
    i2c_rx(1'b0, d); check("R6 continues after wrap", d, 8'h81);
    check("R6 released after NACK", int'(sda_oe), 0);
    i2c_stop();
    i2c_start(); i2c_tx(8'hDF, ack); i2c_rx(1'b0, d); i2c_stop();
    check("R5 current read follows pointer", d, 8'h82);
  endtask

  task automatic t_id_mismatch();
    logic ack; logic [7:0] d;
    i2c_start(); i2c_tx(8'hDE, ack); i2c_tx(8'h10, ack);
    i2c_rstart(); i2c_tx(8'hAF, ack); check("R4 mismatched read identity nacked", ack, 0);
    i2c_rx(1'b0, d); check("R4 no data driven after mismatch", d, 8'hFF);
    i2c_stop();
  endtask

  task automatic t_pwrfail();
    logic ack; logic [7:0] d;
    @(negedge clk); pwr_fail = 1'b1;
    i2c_start(); i2c_tx(8'hDE, ack); check("R8 no ack while cut off", ack, 0);
    i2c_tx(8'h0A, ack); i2c_tx(8'h99, ack); i2c_stop();
    loc_rd(6'd10, d); check("R8 storage kept", d, 8'hA5);
    loc_wr(6'd11, 8'h6B);
    loc_rd(6'd11, d); check("R8 local port works while cut off", d, 8'h6B);
    @(negedge clk); pwr_fail = 1'b0;
    wq();
    i2c_start(); i2c_tx(8'hDE, ack); check("R8 bus back after power", ack, 1); i2c_stop();
  endtask

  task automatic t_clash();
    logic ack; logic [7:0] d;
    i2c_start(); i2c_tx(8'hDE, ack); i2c_tx(8'h20, ack);
    i2c_tx_clash(8'hBB, 6'h20, 8'h44, ack);
    check("R10 bus byte still acked", ack, 1);
    i2c_stop();
    loc_rd(6'h20, d); check("R10 local write wins collision", d, 8'h44);
  endtask

  task automatic t_abort();
    logic ack; logic [7:0] d;
    i2c_start();
    i2c_bit(1'b1); i2c_bit(1'b0); i2c_bit(1'b1);
    i2c_rstart();
    i2c_tx(8'hDE, ack); check("R11 byte recounted after START", ack, 1);
    i2c_tx(8'h09, ack); i2c_tx(8'h99, ack); i2c_stop();
    loc_rd(6'd9, d); check("R11 write after aborted byte", d, 8'h99);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_fail = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    loc_we = 1'b0; loc_addr = '0; loc_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_current_first();
    t_local();
    t_ident();
    t_write();
    t_write_extra();
    t_addr_mod();
    t_random_read();
    t_id_mismatch();
    t_pwrfail();
    t_clash();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule